// File: doc/BRIEF.md
# Thread-Steered One-Shot Event Timer

This block is a per-core event timer shared by sixteen hardware threads. Software arms it in three steps. It writes a terminal value, clears the running count, and writes the control register with both the enable and the run bits set. The count then climbs by one per clock. When it meets the terminal value, the timer latches an expiry. Every thread whose bit is set in a shared thread-select mask receives an interrupt in the same cycle. The expiry stays latched until software writes the control register again.

The thread-select mask can be replaced whole. A thread can also add or remove only its own bit: it writes to a set or clear address, and the block uses the current thread number presented on a side input. A debug halt clears the run bit. This freezes the count until software sets the bit again. All register reads are registered and return data one cycle after the address is presented.

Top module: `tmr_mt_event`

## Requirements
- R1: After reset every register reads 0: count, control, terminal value and thread mask. `thr_irq` is 0.
- R2: The registers sit at fixed addresses: count at 0x21, control at 0x22, terminal value at 0x23 and thread mask at 0x30. `aux_rdata` shows the value of the register at `aux_addr` one cycle later. If a write and a read hit the same register in one cycle, the read returns the value before the write.
- R3: The control register holds the enable bit at bit 0 and the run bit at bit 1. The count advances by exactly one per cycle only while enable=1, run=1, no expiry is pending and the count differs from the terminal value. Otherwise it holds.
- R4: An expiry is latched when the count equals the terminal value while enable=1. The latch clears enable. When the count starts at 0 with terminal value L, the interrupt appears L+1 cycles after the arming control write takes effect. With L=0 it appears one cycle after that write.
- R5: After an expiry the count stays at the terminal value until software writes the count.
- R6: `thr_irq[i]` equals the pending expiry ANDed with mask bit i. All selected threads are raised in the same cycle.
- R7: Any write to the control register clears a pending expiry. A control write with only the run bit set leaves the timer disarmed and the count frozen.
- R8: While `dbg_halt` is 1 the run bit is forced to 0, and this also overrides control writes. The count then holds. The run bit stays 0 after the halt is released, until software writes it again.
- R9: A write to 0x31 sets mask bit `cur_tid`. A write to 0x32 clears mask bit `cur_tid`. Clearing a bit removes that thread's interrupt in the next cycle while the expiry stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_addr | input | 8 | Register address for reads and writes |
| aux_wdata | input | 32 | Write data |
| aux_we | input | 1 | Write strobe |
| aux_rdata | output | 32 | Registered read data |
| dbg_halt | input | 1 | Debug halt request |
| cur_tid | input | 4 | Number of the thread issuing the access |
| thr_irq | output | 16 | Per-thread interrupt lines |

## Verification
The hardest case is a debug halt that arrives in the middle of a countdown. The bench must then confirm three things. The count freezes one cycle after the halt, because the run bit is registered. A control write during the halt cannot restart the count. Only a fresh control write after the halt resumes counting, and expiry then follows on the exact remaining cycle count. The bench reaches this state by arming a long terminal value and raising the halt a known number of cycles into the count. It computes the frozen value from that cycle count and compares the cycle of expiry after resume against the remaining distance. A second hard case is the zero terminal value, where expiry falls on the very first armed cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_COUNT = 8'h21;
  localparam logic [AW-1:0] A_CTRL  = 8'h22;
  localparam logic [AW-1:0] A_LIMIT = 8'h23;
  localparam logic [AW-1:0] A_MASK  = 8'h30;
  localparam logic [AW-1:0] A_MSET  = 8'h31;
  localparam logic [AW-1:0] A_MCLR  = 8'h32;
  localparam int CB_EN  = 0;
  localparam int CB_RUN = 1;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_we,
  input  logic          lim_we,
  input  logic [DW-1:0] wdata,
  input  logic          run,
  output logic [DW-1:0] count,
  output logic [DW-1:0] limit,
  output logic          at_limit
);
  function automatic logic [DW-1:0] step(input logic [DW-1:0] cur,
                                         input logic [DW-1:0] lim,
                                         input logic go);
    return (go && cur != lim) ? cur + 1'b1 : cur;
  endfunction

  assign at_limit = (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      limit <= '0;
    end else begin
      if (lim_we) limit <= wdata;
      if (cnt_we) count <= wdata;
      else        count <= step(count, limit, run);
    end
  end

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: rtl/tmr_tsel.sv
module tmr_tsel #(
  parameter int NT = 16,
  parameter int DW = 32,
  localparam int TW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_all,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] tid,
  output logic [NT-1:0] mask
);
  function automatic logic [NT-1:0] onehot(input logic [TW-1:0] t);
    return {{(NT-1){1'b0}}, 1'b1} << t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (wr_all) mask <= wdata[NT-1:0];
    else if (wr_set) mask <= mask | onehot(tid);
    else if (wr_clr) mask <= mask & ~onehot(tid);
  end

  // R9
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !wr_all |=> !mask[$past(tid)]);
endmodule

// File: rtl/tmr_steer.sv
module tmr_steer #(
  parameter int NT = 16
) (
  input  logic          pending,
  input  logic [NT-1:0] mask,
  output logic [NT-1:0] irq
);
  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign irq[i] = pending & mask[i];
  end
endmodule

// File: rtl/tmr_mt_event.sv
module tmr_mt_event #(
  parameter int NT = 16,
  parameter int DW = 32,
  localparam int TW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    aux_addr,
  input  logic [DW-1:0] aux_wdata,
  input  logic          aux_we,
  output logic [DW-1:0] aux_rdata,
  input  logic          dbg_halt,
  input  logic [TW-1:0] cur_tid,
  output logic [NT-1:0] thr_irq
);
  import tmr_pkg::*;

  logic          ie, nh, pending;
  logic          ctrl_we, cnt_we, lim_we, msk_we, mset_we, mclr_we;
  logic          run, at_limit, expire;
  logic [DW-1:0] count, limit;
  logic [NT-1:0] mask;

  assign ctrl_we = aux_we && aux_addr == A_CTRL;
  assign cnt_we  = aux_we && aux_addr == A_COUNT;
  assign lim_we  = aux_we && aux_addr == A_LIMIT;
  assign msk_we  = aux_we && aux_addr == A_MASK;
  assign mset_we = aux_we && aux_addr == A_MSET;
  assign mclr_we = aux_we && aux_addr == A_MCLR;

  assign run    = ie && nh && !pending;
  assign expire = ie && at_limit && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      nh      <= 1'b0;
      pending <= 1'b0;
    end else if (ctrl_we) begin
      ie      <= aux_wdata[CB_EN];
      nh      <= aux_wdata[CB_RUN] && !dbg_halt;
      pending <= 1'b0;
    end else begin
      if (expire) begin
        pending <= 1'b1;
        ie      <= 1'b0;
      end
      if (dbg_halt) nh <= 1'b0;
    end
  end

  tmr_count #(.DW(DW)) u_count (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .lim_we(lim_we),
    .wdata(aux_wdata), .run(run), .count(count), .limit(limit),
    .at_limit(at_limit)
  );

  tmr_tsel #(.NT(NT), .DW(DW)) u_tsel (
    .clk(clk), .rst_n(rst_n), .wr_all(msk_we), .wr_set(mset_we),
    .wr_clr(mclr_we), .wdata(aux_wdata), .tid(cur_tid), .mask(mask)
  );

  tmr_steer #(.NT(NT)) u_steer (
    .pending(pending), .mask(mask), .irq(thr_irq)
  );

  function automatic logic [DW-1:0] view(input logic [7:0] a);
    logic [DW-1:0] v;
    v = '0;
    case (a)
      A_COUNT: v = count;
      A_LIMIT: v = limit;
      A_MASK:  v[NT-1:0] = mask;
      A_CTRL:  begin v[CB_EN] = ie; v[CB_RUN] = nh; end
      default: v = '0;
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_rdata <= '0;
    else        aux_rdata <= view(aux_addr);
  end

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !pending);
  // R4
  expiry_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ie && at_limit && !pending && !ctrl_we |=> pending && !ie);
  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !cnt_we |=> $stable(count));
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nh && !cnt_we |=> $stable(count));
  // R8
  halt_run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |=> !nh);
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> thr_irq == '0);
endmodule

// File: tb/test_tmr_mt_event.sv
module test_tmr_mt_event;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  aux_addr = '0;
  logic [31:0] aux_wdata = '0;
  logic        aux_we = 1'b0;
  logic [31:0] aux_rdata;
  logic        dbg_halt = 1'b0;
  logic [3:0]  cur_tid = '0;
  logic [15:0] thr_irq;

  localparam logic [7:0] COUNT = 8'h21, CTRL = 8'h22, LIMIT = 8'h23;
  localparam logic [7:0] MASK = 8'h30, MSET = 8'h31, MCLR = 8'h32;

  int cyc = 0, checks = 0, failures = 0;
  bit done = 1'b0;

  int          due_q[$];
  bit          irq_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  tmr_mt_event i_tmr_mt_event (
    .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
    .aux_we(aux_we), .aux_rdata(aux_rdata), .dbg_halt(dbg_halt),
    .cur_tid(cur_tid), .thr_irq(thr_irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops scoreboard items when due
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [31:0] act;
      act = irq_q[0] ? {16'h0, thr_irq} : aux_rdata;
      checks++;
      if (act !== exp_q[0]) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", tag_q[0], act, exp_q[0]);
      end
      void'(due_q.pop_front()); void'(irq_q.pop_front());
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push(input bit is_irq, input logic [31:0] e, input string t);
    due_q.push_back(cyc + 1); irq_q.push_back(is_irq);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    aux_addr = a; aux_wdata = d; aux_we = 1'b1;
    @(negedge clk);
    aux_we = 1'b0;
  endtask

  task automatic wr_rd(input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] old, input string t);
    push(1'b0, old, t);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    aux_addr = a; push(1'b0, e, t);
    @(negedge clk);
  endtask

  task automatic irq_next(input logic [15:0] e, input string t);
    push(1'b1, {16'h0, e}, t);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(COUNT, 0, "R1 count"); rd(CTRL, 0, "R1 ctrl");
    rd(LIMIT, 0, "R1 limit"); rd(MASK, 0, "R1 mask");
    irq_next(16'h0, "R1 irq");
    // R2 readback and read-during-write
    wr(LIMIT, 32'h1234); rd(LIMIT, 32'h1234, "R2 readback");
    aux_addr = LIMIT;
    wr_rd(LIMIT, 32'd5, 32'h1234, "R2 old value on same-cycle write");
    rd(LIMIT, 5, "R2 new value");
    // R9 per-thread set/clear
    cur_tid = 4'd3;  wr(MSET, 0);
    cur_tid = 4'd7;  wr(MSET, 0);
    cur_tid = 4'd12; wr(MSET, 0);
    rd(MASK, 32'h1088, "R9 set bits");
    wr(MCLR, 0);
    rd(MASK, 32'h0088, "R9 clear bit");
    // R3/R4/R6 arming, L=5
    wr(LIMIT, 5); wr(COUNT, 0); wr(CTRL, 3);
    idle(1);
    rd(COUNT, 1, "R3 count mid-run");
    idle(2);
    irq_next(16'h0, "R4 no irq before L+1");
    irq_next(16'h0088, "R4 R6 irq to all selected");
    rd(COUNT, 5, "R5 held at limit");
    idle(3);
    rd(COUNT, 5, "R5 still held");
    rd(CTRL, 2, "R4 enable cleared on expiry");
    // R9 dropping own bit while pending
    cur_tid = 4'd3; wr(MCLR, 0);
    irq_next(16'h0080, "R9 own irq dropped");
    // R7 acknowledge with run only
    wr(CTRL, 2);
    irq_next(16'h0, "R7 ack clears irq");
    rd(CTRL, 2, "R7 disarmed");
    rd(COUNT, 5, "R7 count frozen");
    // R4 zero terminal value
    wr(LIMIT, 0); wr(COUNT, 0); wr(CTRL, 3);
    irq_next(16'h0080, "R4 limit zero expiry");
    wr(CTRL, 0);
    // R8 debug halt mid-count, L=10
    cur_tid = 4'd0; wr(MSET, 0);
    wr(LIMIT, 10); wr(COUNT, 0); wr(CTRL, 3);
    idle(2);
    dbg_halt = 1'b1;
    idle(20);
    irq_next(16'h0, "R8 no expiry while halted");
    rd(COUNT, 3, "R8 count frozen");
    rd(CTRL, 1, "R8 run bit cleared");
    wr(CTRL, 3);
    rd(CTRL, 1, "R8 halt overrides write");
    dbg_halt = 1'b0;
    idle(3);
    rd(COUNT, 3, "R8 stays frozen after release");
    wr(CTRL, 3);
    idle(6);
    irq_next(16'h0, "R8 resume not yet expired");
    irq_next(16'h0081, "R8 resume expiry on time");
    wr(CTRL, 0);
    // R7 run-only write leaves timer disarmed
    wr(LIMIT, 2); wr(COUNT, 0); wr(CTRL, 2);
    idle(10);
    irq_next(16'h0, "R7 no expiry when disarmed");
    rd(COUNT, 0, "R3 no advance without enable");
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule